// File: doc/BRIEF.md
# Condition Flags Register with Shared Status Bus

This block keeps the condition flags of a small 16-bit processor. It holds a bank of result registers. Each register works out its own Zero, Negative, Carry and Overflow conditions for the value it is about to take. A register places those conditions on a shared 4-bit status bus only in a cycle where it is loaded, incremented or decremented. No separate select line exists: the update strobe is the selection. When two registers step in the same cycle, the bus carries the bitwise OR of both condition sets.

An 8-bit flag byte latches the bus. Z, N, C and V each have their own load enable, decoded from the instruction class and allowed only in the final cycle of an instruction. The byte also holds an interrupt-enable bit. That bit is set and cleared by dedicated point-to-point strobes and never by the status bus. Three more bits are reserved: they can be stored and read back but have no other use. The whole byte is always visible at the outputs, so a call or interrupt entry can push it. A restore strobe reloads all eight bits on return, which brings back the interrupt-enable state that held before a nested interrupt.

Top module: `cflag_unit`

## Requirements
- R1: While `rst_n` is low, all flag bits and all result registers are 0, so interrupts start disabled.
- R2: A load strobe writes `reg_din` into its register at the next clock edge. In that cycle the register reports Z = (din == 0), N = din[15], C = `alu_c` and V = `alu_v`.
- R3: An increment adds 1 and a decrement subtracts 1, both modulo 2^16. Z and N describe the new value. C is set on an increment of 0xFFFF or a decrement of 0x0000. V is set on an increment of 0x7FFF or a decrement of 0x8000.
- R4: `status_bus` is 0 in any cycle where no register has a strobe. When exactly one register is updating, the bus equals that register's conditions, with bit 0 = Z, 1 = N, 2 = C, 3 = V.
- R5: When two or more registers update in the same cycle, each bit of `status_bus` is the OR of that bit across the updating registers.
- R6: With `instr_last` high and `instr_class` = 2'b00 (ALU), Z, N, C and V all take the `status_bus` value at the clock edge.
- R7: With `instr_last` high, class 2'b01 (transfer) loads only Z and N, class 2'b10 (step) loads Z, N and V, and class 2'b11 (branch) loads no flag. Flags that are not loaded keep their value.
- R8: With `instr_last` low, no condition flag changes, whatever the bus carries.
- R9: `ie_set` sets flag bit 4 and `ie_clr` clears it at the next edge. `ie_clr` wins when both are high. The status bus never alters bit 4.
- R10: `restore_en` loads all 8 bits from `restore_byte` at the next edge, including reserved bits 7 to 5. It overrides flag loads and interrupt-enable strobes in the same cycle.
- R11: `flags_q` shows the stored byte at all times (Z=0, N=1, C=2, V=3, IE=4, reserved 7:5). `cond_out` mirrors bits 3:0 and `ie_out` mirrors bit 4.
- R12: When a register receives more than one strobe in a cycle, load takes precedence over increment, and increment takes precedence over decrement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_ld | input | NUM_RES | Per-register load strobe |
| reg_inc | input | NUM_RES | Per-register increment strobe |
| reg_dec | input | NUM_RES | Per-register decrement strobe |
| reg_din | input | DATA_W | Shared load data |
| alu_c | input | 1 | Carry that comes with a load |
| alu_v | input | 1 | Overflow that comes with a load |
| instr_class | input | 2 | 00 ALU, 01 transfer, 10 step, 11 branch |
| instr_last | input | 1 | Final cycle of the current instruction |
| ie_set | input | 1 | Set interrupt enable |
| ie_clr | input | 1 | Clear interrupt enable |
| restore_en | input | 1 | Reload the whole flag byte |
| restore_byte | input | 8 | Byte to reload |
| status_bus | output | 4 | Combined conditions of the updating registers |
| flags_q | output | 8 | Stored flag byte |
| cond_out | output | 4 | Current Z, N, C, V |
| ie_out | output | 1 | Current interrupt enable |
| reg_value | output | NUM_RES*DATA_W | Result register contents, register i at [i*DATA_W +: DATA_W] |

## Verification
The hardest cases to reach are carry and overflow from a step. They need a register that already holds exactly 0x7FFF, 0xFFFF, 0x0000 or 0x8000 when it is stepped, and a full width of random data almost never lands there. Other hard cases are a dual step whose two condition sets differ, and a restore that arrives in the same cycle as flag loads. The stimulus draws its load data mostly from those four boundary values, so random steps often follow a boundary load. A directed prologue first builds each of these cases on purpose: boundary loads, single and paired steps, and a restore raised together with an ALU final cycle and both interrupt strobes.

// File: rtl/cflag_pkg.sv
package cflag_pkg;

  localparam int FLAG_W = 8;
  localparam int COND_W = 4;

  localparam int Z_POS  = 0;
  localparam int N_POS  = 1;
  localparam int C_POS  = 2;
  localparam int V_POS  = 3;
  localparam int IE_POS = 4;

  typedef enum logic [1:0] {
    CLS_ALU    = 2'b00,
    CLS_XFER   = 2'b01,
    CLS_STEP   = 2'b10,
    CLS_BRANCH = 2'b11
  } instr_cls_e;

  // Packed so that z lands on bit 0.
  typedef struct packed {
    logic v;
    logic c;
    logic n;
    logic z;
  } cond_t;

  localparam cond_t COND_NONE = '{v: 1'b0, c: 1'b0, n: 1'b0, z: 1'b0};

  // Which condition flags a given instruction class is allowed to load.
  function automatic cond_t class_mask(instr_cls_e cls);
    cond_t m;
    m = COND_NONE;
    case (cls)
      CLS_ALU:  m = '{v: 1'b1, c: 1'b1, n: 1'b1, z: 1'b1};
      CLS_XFER: m = '{v: 1'b0, c: 1'b0, n: 1'b1, z: 1'b1};
      CLS_STEP: m = '{v: 1'b1, c: 1'b0, n: 1'b1, z: 1'b1};
      default:  m = COND_NONE;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/cflag_result_reg.sv
module cflag_result_reg
  import cflag_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic              inc,
  input  logic              dec,
  input  logic [DATA_W-1:0] din,
  input  logic              alu_c,
  input  logic              alu_v,
  output logic [DATA_W-1:0] q,
  output logic              upd,
  output cond_t             stat
);

  localparam logic [DATA_W:0] ONE_EXT = {{DATA_W{1'b0}}, 1'b1};

  // Extended sum: bit DATA_W is the carry out.
  function automatic logic [DATA_W:0] step_up(logic [DATA_W-1:0] a);
    return {1'b0, a} + ONE_EXT;
  endfunction

  // Extended difference: bit DATA_W is the borrow.
  function automatic logic [DATA_W:0] step_down(logic [DATA_W-1:0] a);
    return {1'b0, a} - ONE_EXT;
  endfunction

  // Signed overflow of +1: positive operand, negative result.
  function automatic logic ovf_up(logic [DATA_W-1:0] a, logic [DATA_W-1:0] r);
    return ~a[DATA_W-1] & r[DATA_W-1];
  endfunction

  // Signed overflow of -1: negative operand, positive result.
  function automatic logic ovf_down(logic [DATA_W-1:0] a, logic [DATA_W-1:0] r);
    return a[DATA_W-1] & ~r[DATA_W-1];
  endfunction

  logic [DATA_W-1:0] q_r;
  logic [DATA_W-1:0] nxt;
  logic [DATA_W:0]   up_ext;
  logic [DATA_W:0]   dn_ext;
  cond_t             own;

  assign up_ext = step_up(q_r);
  assign dn_ext = step_down(q_r);
  assign upd    = ld | inc | dec;

  always_comb begin
    nxt = q_r;
    own = COND_NONE;
    if (ld) begin
      nxt   = din;
      own.c = alu_c;
      own.v = alu_v;
    end else if (inc) begin
      nxt   = up_ext[DATA_W-1:0];
      own.c = up_ext[DATA_W];
      own.v = ovf_up(q_r, up_ext[DATA_W-1:0]);
    end else if (dec) begin
      nxt   = dn_ext[DATA_W-1:0];
      own.c = dn_ext[DATA_W];
      own.v = ovf_down(q_r, dn_ext[DATA_W-1:0]);
    end
    own.z = (nxt == '0);
    own.n = nxt[DATA_W-1];
  end

  // The update strobe is the only bus select.
  assign stat = upd ? own : COND_NONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else if (upd) q_r <= nxt;
  end

  assign q = q_r;

endmodule

// File: rtl/cflag_bus_merge.sv
module cflag_bus_merge
  import cflag_pkg::*;
#(
  parameter int NUM_SRC = 4
) (
  input  logic [NUM_SRC*COND_W-1:0] src_flat,
  output cond_t                     bus
);

  logic [COND_W-1:0] acc [NUM_SRC+1];

  assign acc[0] = '0;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_or
      assign acc[gi+1] = acc[gi] | src_flat[gi*COND_W +: COND_W];
    end
  endgenerate

  assign bus = cond_t'(acc[NUM_SRC]);

endmodule

// File: rtl/cflag_load_decode.sv
module cflag_load_decode
  import cflag_pkg::*;
(
  input  logic [1:0] instr_class,
  input  logic       instr_last,
  output cond_t      ld_mask
);

  assign ld_mask = instr_last ? class_mask(instr_cls_e'(instr_class)) : COND_NONE;

endmodule

// File: rtl/cflag_store.sv
module cflag_store
  import cflag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  cond_t             bus,
  input  cond_t             ld_mask,
  input  logic              ie_set,
  input  logic              ie_clr,
  input  logic              restore_en,
  input  logic [FLAG_W-1:0] restore_byte,
  output logic [FLAG_W-1:0] flags_q
);

  logic [FLAG_W-1:0] f_r;
  logic [FLAG_W-1:0] f_nxt;

  // Condition bits take the bus only where their enable is set.
  function automatic logic [COND_W-1:0] merge_cond(logic [COND_W-1:0] old_v,
                                                   logic [COND_W-1:0] new_v,
                                                   logic [COND_W-1:0] en);
    return (old_v & ~en) | (new_v & en);
  endfunction

  always_comb begin
    f_nxt = f_r;
    if (restore_en) begin
      f_nxt = restore_byte;
    end else begin
      f_nxt[COND_W-1:0] = merge_cond(f_r[COND_W-1:0], bus, ld_mask);
      if (ie_clr)      f_nxt[IE_POS] = 1'b0;
      else if (ie_set) f_nxt[IE_POS] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) f_r <= '0;
    else        f_r <= f_nxt;
  end

  assign flags_q = f_r;

endmodule

// File: rtl/cflag_unit.sv
module cflag_unit
  import cflag_pkg::*;
#(
  parameter int NUM_RES = 4,
  parameter int DATA_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_RES-1:0]        reg_ld,
  input  logic [NUM_RES-1:0]        reg_inc,
  input  logic [NUM_RES-1:0]        reg_dec,
  input  logic [DATA_W-1:0]         reg_din,
  input  logic                      alu_c,
  input  logic                      alu_v,
  input  logic [1:0]                instr_class,
  input  logic                      instr_last,
  input  logic                      ie_set,
  input  logic                      ie_clr,
  input  logic                      restore_en,
  input  logic [7:0]                restore_byte,
  output logic [3:0]                status_bus,
  output logic [7:0]                flags_q,
  output logic [3:0]                cond_out,
  output logic                      ie_out,
  output logic [NUM_RES*DATA_W-1:0] reg_value
);

  localparam int STAT_FLAT_W = NUM_RES * COND_W;

  // Named internal events, brought out for the checker.
  logic [NUM_RES-1:0]     reg_upd;
  logic [STAT_FLAT_W-1:0] stat_flat;
  cond_t                  merged;
  cond_t                  flag_ld_mask;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_RES; gi++) begin : g_res
      cond_t one_stat;
      cflag_result_reg #(.DATA_W(DATA_W)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (reg_ld[gi]),
        .inc   (reg_inc[gi]),
        .dec   (reg_dec[gi]),
        .din   (reg_din),
        .alu_c (alu_c),
        .alu_v (alu_v),
        .q     (reg_value[gi*DATA_W +: DATA_W]),
        .upd   (reg_upd[gi]),
        .stat  (one_stat)
      );
      assign stat_flat[gi*COND_W +: COND_W] = one_stat;
    end
  endgenerate

  cflag_bus_merge #(.NUM_SRC(NUM_RES)) u_merge (
    .src_flat (stat_flat),
    .bus      (merged)
  );

  cflag_load_decode u_dec (
    .instr_class (instr_class),
    .instr_last  (instr_last),
    .ld_mask     (flag_ld_mask)
  );

  cflag_store u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus          (merged),
    .ld_mask      (flag_ld_mask),
    .ie_set       (ie_set),
    .ie_clr       (ie_clr),
    .restore_en   (restore_en),
    .restore_byte (restore_byte),
    .flags_q      (flags_q)
  );

  assign status_bus = merged;
  assign cond_out   = flags_q[COND_W-1:0];
  assign ie_out     = flags_q[IE_POS];

endmodule

// File: rtl/cflag_unit_chk.sv
module cflag_unit_chk #(
  parameter int NUM_RES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_RES-1:0] reg_upd,
  input logic [3:0]         status_bus,
  input logic [3:0]         flag_ld_mask,
  input logic [1:0]         instr_class,
  input logic               instr_last,
  input logic               ie_set,
  input logic               ie_clr,
  input logic               restore_en,
  input logic [7:0]         restore_byte,
  input logic [7:0]         flags_q
);

  assert_bus_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_upd == '0) |-> (status_bus == 4'b0000));

  assert_no_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_last |-> (flag_ld_mask == 4'b0000));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!restore_en && !instr_last && !ie_set && !ie_clr) |=> $stable(flags_q));

  assert_alu_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!restore_en && instr_last && instr_class == 2'b00)
      |=> (flags_q[3:0] == $past(status_bus)));

  assert_branch_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!restore_en && instr_last && instr_class == 2'b11)
      |=> (flags_q[3:0] == $past(flags_q[3:0])));

  assert_ie_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!restore_en && ie_clr) |=> !flags_q[4]);

  assert_restore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restore_en |=> (flags_q == $past(restore_byte)));

endmodule

bind cflag_unit cflag_unit_chk #(.NUM_RES(NUM_RES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_upd      (reg_upd),
  .status_bus   (status_bus),
  .flag_ld_mask (flag_ld_mask),
  .instr_class  (instr_class),
  .instr_last   (instr_last),
  .ie_set       (ie_set),
  .ie_clr       (ie_clr),
  .restore_en   (restore_en),
  .restore_byte (restore_byte),
  .flags_q      (flags_q)
);

// File: tb/cflag_unit_tb.sv
module cflag_unit_tb;

  localparam int NR = 4;
  localparam int W  = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NR-1:0] reg_ld = '0, reg_inc = '0, reg_dec = '0;
  logic [W-1:0]  reg_din = '0;
  logic          alu_c = 1'b0, alu_v = 1'b0;
  logic [1:0]    instr_class = 2'b00;
  logic          instr_last = 1'b0, ie_set = 1'b0, ie_clr = 1'b0, restore_en = 1'b0;
  logic [7:0]    restore_byte = '0;
  logic [3:0]    status_bus;
  logic [7:0]    flags_q;
  logic [3:0]    cond_out;
  logic          ie_out;
  logic [NR*W-1:0] reg_value;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [W-1:0] m_reg [NR];
  logic [7:0]   m_flags;

  always #5 clk = ~clk;

  cflag_unit #(.NUM_RES(NR), .DATA_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_ld(reg_ld), .reg_inc(reg_inc), .reg_dec(reg_dec),
    .reg_din(reg_din), .alu_c(alu_c), .alu_v(alu_v), .instr_class(instr_class),
    .instr_last(instr_last), .ie_set(ie_set), .ie_clr(ie_clr), .restore_en(restore_en),
    .restore_byte(restore_byte), .status_bus(status_bus), .flags_q(flags_q),
    .cond_out(cond_out), .ie_out(ie_out), .reg_value(reg_value)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Next value and conditions of one register: {cond[3:0], value}.
  function automatic logic [W+3:0] model_reg(logic [W-1:0] cur, bit ld, bit inc, bit dec,
                                             logic [W-1:0] din, bit c_in, bit v_in);
    int unsigned nv;
    bit c, v;
    if (ld) begin
      nv = din; c = c_in; v = v_in;
    end else if (inc) begin
      nv = (cur + 1) % 65536; c = (cur == 16'hFFFF); v = (cur == 16'h7FFF);
    end else begin
      nv = (cur + 65535) % 65536; c = (cur == 16'h0000); v = (cur == 16'h8000);
    end
    return {v, c, (nv >= 32768), (nv == 0), nv[W-1:0]};
  endfunction

  function automatic logic [3:0] class_bits(logic [1:0] cls);
    case (cls)
      2'b00: return 4'b1111;
      2'b01: return 4'b0011;
      2'b10: return 4'b1011;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic cycle(logic [NR-1:0] ld, logic [NR-1:0] inc, logic [NR-1:0] dec,
                       logic [W-1:0] din, bit c, bit v, logic [1:0] cls, bit last,
                       bit ies, bit iec, bit rst_en, logic [7:0] rb);
    logic [3:0] exp_bus;
    logic [W+3:0] r;
    int nupd;
    string tag;
    @(negedge clk);
    reg_ld = ld; reg_inc = inc; reg_dec = dec; reg_din = din; alu_c = c; alu_v = v;
    instr_class = cls; instr_last = last; ie_set = ies; ie_clr = iec;
    restore_en = rst_en; restore_byte = rb;
    #1;
    exp_bus = '0; nupd = 0;
    for (int i = 0; i < NR; i++) begin
      if (ld[i] | inc[i] | dec[i]) begin
        r = model_reg(m_reg[i], ld[i], inc[i], dec[i], din, c, v);
        exp_bus |= r[W+3:W];
        nupd++;
        m_reg[i] = r[W-1:0];
      end
    end
    check(nupd > 1 ? "R5 merged bus" : "R4 status bus", status_bus, exp_bus);
    if (rst_en) m_flags = rb;
    else begin
      if (last) begin
        for (int b = 0; b < 4; b++)
          if (class_bits(cls)[b]) m_flags[b] = exp_bus[b];
      end
      if (iec) m_flags[4] = 1'b0;
      else if (ies) m_flags[4] = 1'b1;
    end
    @(posedge clk); #1;
    if (rst_en) tag = "R10 restore";
    else if (ies | iec) tag = "R9 ie";
    else if (!last) tag = "R8 no load";
    else if (cls == 2'b00) tag = "R6 alu";
    else tag = "R7 class mask";
    check(tag, flags_q, m_flags);
    check("R11 mirrors", {ie_out, cond_out}, m_flags[4:0]);
    for (int i = 0; i < NR; i++) begin
      if (ld[i] & (inc[i] | dec[i])) tag = "R12 precedence";
      else if (ld[i]) tag = "R2 load";
      else tag = "R3 step";
      if (ld[i] | inc[i] | dec[i])
        check(tag, reg_value[i*W +: W], m_reg[i]);
    end
  endtask

  function automatic logic [W-1:0] pick_data();
    case ($urandom % 6)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h7FFF;
      3: return 16'h8000;
      default: return W'($urandom);
    endcase
  endfunction

  initial begin
    #(200000 * 10);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NR; i++) m_reg[i] = '0;
    m_flags = '0;
    repeat (3) @(negedge clk);
    check("R1 reset flags", flags_q, 8'h00);
    check("R1 reset regs", reg_value, '0);
    rst_n = 1'b1;
    // Directed corners.
    cycle(4'b0001, 0, 0, 16'h7FFF, 0, 0, 2'b01, 1, 0, 0, 0, 0);
    cycle(0, 4'b0001, 0, 0, 0, 0, 2'b10, 1, 0, 0, 0, 0);       // V and N
    cycle(4'b0010, 0, 0, 16'hFFFF, 1, 1, 2'b00, 1, 0, 0, 0, 0); // load C/V
    cycle(0, 4'b0010, 0, 0, 0, 0, 2'b00, 1, 0, 0, 0, 0);       // wrap to zero, carry
    cycle(0, 0, 4'b0010, 0, 0, 0, 2'b00, 1, 0, 0, 0, 0);       // borrow from zero
    cycle(4'b0100, 0, 0, 16'h8000, 0, 0, 2'b11, 1, 0, 0, 0, 0); // branch keeps
    cycle(0, 0, 4'b0100, 0, 0, 0, 2'b10, 1, 0, 0, 0, 0);       // dec 8000 overflow
    cycle(0, 4'b0011, 0, 0, 0, 0, 2'b10, 1, 0, 0, 0, 0);       // dual step OR
    cycle(0, 4'b1111, 0, 0, 0, 0, 2'b00, 0, 0, 0, 0, 0);       // no load when not last
    cycle(4'b1000, 4'b1000, 4'b1000, 16'h1234, 0, 0, 2'b00, 1, 0, 0, 0, 0);
    cycle(0, 0, 0, 0, 0, 0, 2'b00, 0, 1, 1, 0, 0);             // clear wins
    cycle(0, 0, 0, 0, 0, 0, 2'b00, 0, 1, 0, 0, 0);             // set
    cycle(0, 4'b0001, 0, 0, 0, 0, 2'b00, 1, 1, 1, 1, 8'hA5);   // restore wins
    cycle(0, 0, 0, 0, 0, 0, 2'b00, 0, 0, 0, 1, 8'hE0);
    // Random mix.
    for (int n = 0; n < 600; n++) begin
      logic [NR-1:0] l, u, d;
      l = '0; u = '0; d = '0;
      case ($urandom % 5)
        0: ;
        1: l[$urandom % NR] = 1'b1;
        2: u[$urandom % NR] = 1'b1;
        3: d[$urandom % NR] = 1'b1;
        default: begin
          l = NR'($urandom) & NR'($urandom);
          u = NR'($urandom);
          d = NR'($urandom);
        end
      endcase
      cycle(l, u, d, pick_data(), 1'($urandom), 1'($urandom), 2'($urandom),
            ($urandom % 4) != 0, ($urandom % 8) == 0, ($urandom % 8) == 0,
            ($urandom % 10) == 0, 8'($urandom));
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule